// File: doc/BRIEF.md
# Split-Half GPIO with Edge Interrupts

This block holds a 32-pin general-purpose I/O port behind a register bus that is 16 bits wide. Each 32-bit register is reached as two halves: the low half in a low offset group and the high half at the same offset plus a high-group base. The port has an output register, an input view of the pins, a rising-edge enable, a falling-edge enable and an interrupt status register. The status register records only the mask of the most recent qualifying edge.

Input pins pass through a two-flop synchroniser. Edges are found by comparing the two synchroniser stages. Three output lines carry a brightness level. The level is decoded from output bits 18:16 together with three enable bits kept in the high output-enable register. Output bits 29 and 30 drive a pair of I2C data and clock lines directly.

Top module: `gpio_halfword_edge`

## Requirements
- R1: Register offsets in the low group are output-enable 0x008, output 0x00C, input 0x010, falling enable 0x014, rising enable 0x018 and status 0x020. The high-half registers are at the same offsets plus 0x500. A read returns the addressed 16-bit half right-aligned. An unmapped address reads 0. Writes to either input half are ignored.
- R2: A write to a half changes only that 16-bit half of the 32-bit register, using write data bits 15:0.
- R3: Reset leaves the input view reading 0xFFFF in both halves. It clears output, both enables, status and the output-enable bits. After reset irq is low, the brightness level is 7 and both I2C lines are 0.
- R4: A 0-to-1 change on a pin whose rising-enable bit is set overwrites status with that pin's one-hot mask. The change is recorded on the second rising clock edge after it appears on the pin.
- R5: A 1-to-0 change on a pin whose falling-enable bit is set overwrites status with that pin's one-hot mask, with the same timing as R4.
- R6: A pin change without a matching enable bit leaves status and irq unchanged. The input register still follows the pin.
- R7: Status never holds more than one set bit. A later qualifying edge replaces the mask of an earlier one without any clear in between.
- R8: If several pins qualify on the same clock edge, the mask of the lowest-numbered pin is recorded.
- R9: irq is high exactly while status is nonzero. A write of any value to either status half clears all 32 status bits. A qualifying edge on the same clock edge as the clear wins.
- R10: A write to the high output-enable register (0x508) keeps only data bits 2:0. Reading 0x508 returns those 3 bits. The low output-enable register (0x008) reads 0 and ignores writes.
- R11: The brightness level is decoded from output bits 18:16 (value O) and the 0x508 bits (value E): O=0,E=7 gives 0; O=2,E=0 gives 1; O=2,E=1 gives 2; O=4,E=0 gives 3; O=1,E=6 gives 4; O=2,E=5 gives 5; O=4,E=3 gives 6. Any other pair gives 7. The level changes only on writes to 0x50C or 0x508.
- R12: i2c_sda equals output bit 29 and i2c_scl equals output bit 30 (data bits 13 and 14 of a 0x50C write). They change only on writes to 0x50C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | AW (12) | Register byte offset |
| reg_wdata | input | 16 | Write data for the addressed half |
| reg_rdata | output | 16 | Read data of the addressed half, combinational |
| pin_i | input | 32 | Input pins, asynchronous |
| irq | output | 1 | Interrupt, high while status is nonzero |
| bright_lvl | output | 3 | Decoded brightness level |
| i2c_sda | output | 1 | I2C data line from output bit 29 |
| i2c_scl | output | 1 | I2C clock line from output bit 30 |

## Verification
The checker watches several behaviours on every cycle:
- status never holds more than one set bit;
- irq only rises after a qualifying edge;
- a clear with no competing edge drops irq;
- the I2C lines copy a high output write and otherwise stay put;
- the brightness level moves only on its two trigger writes.

Only the bench scenarios can show the rest:
- the exact address map and half isolation;
- the two-edge latency from pin to status;
- lowest-pin priority;
- the edge-over-clear race;
- every entry of the brightness table.

// File: rtl/gpio_halfword_edge.sv
`timescale 1ns/1ps
module gpio_halfword_edge #(
  parameter int AW = 12,
  parameter logic [AW-1:0] HI_OFS = AW'('h500)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic [31:0]   pin_i,
  output logic          irq,
  output logic [2:0]    bright_lvl,
  output logic          i2c_sda,
  output logic          i2c_scl
);
  localparam logic [AW-1:0] A_OE_LO   = AW'('h008);
  localparam logic [AW-1:0] A_OUT_LO  = AW'('h00C);
  localparam logic [AW-1:0] A_IN_LO   = AW'('h010);
  localparam logic [AW-1:0] A_FALL_LO = AW'('h014);
  localparam logic [AW-1:0] A_RISE_LO = AW'('h018);
  localparam logic [AW-1:0] A_STAT_LO = AW'('h020);
  localparam logic [AW-1:0] A_OE_HI   = HI_OFS + A_OE_LO;
  localparam logic [AW-1:0] A_OUT_HI  = HI_OFS + A_OUT_LO;
  localparam logic [AW-1:0] A_IN_HI   = HI_OFS + A_IN_LO;
  localparam logic [AW-1:0] A_FALL_HI = HI_OFS + A_FALL_LO;
  localparam logic [AW-1:0] A_RISE_HI = HI_OFS + A_RISE_LO;
  localparam logic [AW-1:0] A_STAT_HI = HI_OFS + A_STAT_LO;

  logic [31:0] sync_a, sync_b;
  logic [31:0] out_q, rise_en, fall_en, stat_q;
  logic [2:0]  oe_bits, bright_q;
  logic [31:0] qual, pick;
  logic        stat_clr;

  function automatic logic [2:0] bright_decode(input logic [2:0] o, input logic [2:0] e);
    case ({o, e})
      {3'd0, 3'd7}: return 3'd0;
      {3'd2, 3'd0}: return 3'd1;
      {3'd2, 3'd1}: return 3'd2;
      {3'd4, 3'd0}: return 3'd3;
      {3'd1, 3'd6}: return 3'd4;
      {3'd2, 3'd5}: return 3'd5;
      {3'd4, 3'd3}: return 3'd6;
      default:      return 3'd7;
    endcase
  endfunction

  assign qual = (sync_a & ~sync_b & rise_en) | (~sync_a & sync_b & fall_en);
  assign pick = qual & (~qual + 32'd1);
  assign stat_clr = reg_we && (reg_addr == A_STAT_LO || reg_addr == A_STAT_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '1;
      sync_b <= '1;
    end else begin
      sync_a <= pin_i;
      sync_b <= sync_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      rise_en  <= '0;
      fall_en  <= '0;
      oe_bits  <= '0;
      bright_q <= 3'd7;
    end else if (reg_we) begin
      case (reg_addr)
        A_OUT_LO:  out_q[15:0]    <= reg_wdata;
        A_OUT_HI: begin
          out_q[31:16] <= reg_wdata;
          bright_q     <= bright_decode(reg_wdata[2:0], oe_bits);
        end
        A_OE_HI: begin
          oe_bits  <= reg_wdata[2:0];
          bright_q <= bright_decode(out_q[18:16], reg_wdata[2:0]);
        end
        A_RISE_LO: rise_en[15:0]  <= reg_wdata;
        A_RISE_HI: rise_en[31:16] <= reg_wdata;
        A_FALL_LO: fall_en[15:0]  <= reg_wdata;
        A_FALL_HI: fall_en[31:16] <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         stat_q <= '0;
    else if (|qual)     stat_q <= pick;
    else if (stat_clr)  stat_q <= '0;
  end

  always_comb begin
    case (reg_addr)
      A_OE_HI:   reg_rdata = {13'd0, oe_bits};
      A_OUT_LO:  reg_rdata = out_q[15:0];
      A_OUT_HI:  reg_rdata = out_q[31:16];
      A_IN_LO:   reg_rdata = sync_b[15:0];
      A_IN_HI:   reg_rdata = sync_b[31:16];
      A_FALL_LO: reg_rdata = fall_en[15:0];
      A_FALL_HI: reg_rdata = fall_en[31:16];
      A_RISE_LO: reg_rdata = rise_en[15:0];
      A_RISE_HI: reg_rdata = rise_en[31:16];
      A_STAT_LO: reg_rdata = stat_q[15:0];
      A_STAT_HI: reg_rdata = stat_q[31:16];
      default:   reg_rdata = 16'd0;
    endcase
  end

  assign irq        = |stat_q;
  assign bright_lvl = bright_q;
  assign i2c_sda    = out_q[29];
  assign i2c_scl    = out_q[30];
endmodule

module gpio_halfword_edge_chk #(
  parameter int AW = 12,
  parameter logic [AW-1:0] HI_OFS = AW'('h500)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          wd_sda,
  input logic          wd_scl,
  input logic          irq,
  input logic [2:0]    bright_lvl,
  input logic          i2c_sda,
  input logic          i2c_scl,
  input logic [31:0]   stat_q,
  input logic [31:0]   qual
);
  localparam logic [AW-1:0] C_OE_HI   = HI_OFS + AW'('h008);
  localparam logic [AW-1:0] C_OUT_HI  = HI_OFS + AW'('h00C);
  localparam logic [AW-1:0] C_STAT_LO = AW'('h020);
  localparam logic [AW-1:0] C_STAT_HI = HI_OFS + AW'('h020);

  logic wr_out_hi, wr_bright, wr_stat;
  assign wr_out_hi = reg_we && reg_addr == C_OUT_HI;
  assign wr_bright = reg_we && (reg_addr == C_OUT_HI || reg_addr == C_OE_HI);
  assign wr_stat   = reg_we && (reg_addr == C_STAT_LO || reg_addr == C_STAT_HI);

  assert_status_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_q));

  assert_irq_after_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (qual != 32'd0) |=> irq);

  assert_irq_rise_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(qual != 32'd0));

  assert_clear_drops_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && qual == 32'd0) |=> !irq);

  assert_i2c_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_hi |=> (i2c_sda == $past(wd_sda) && i2c_scl == $past(wd_scl)));

  assert_i2c_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_out_hi |=> ($stable(i2c_sda) && $stable(i2c_scl)));

  assert_bright_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_bright |=> $stable(bright_lvl));
endmodule

bind gpio_halfword_edge gpio_halfword_edge_chk #(.AW(AW), .HI_OFS(HI_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .wd_sda(reg_wdata[13]), .wd_scl(reg_wdata[14]),
  .irq(irq), .bright_lvl(bright_lvl), .i2c_sda(i2c_sda), .i2c_scl(i2c_scl),
  .stat_q(stat_q), .qual(qual)
);

// File: tb/gpio_halfword_edge_bench.sv
`timescale 1ns/1ps
module gpio_halfword_edge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [31:0] pin_i = '1;
  logic        irq;
  logic [2:0]  bright_lvl;
  logic        i2c_sda, i2c_scl;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [11:0] OE_LO = 12'h008, OUT_LO = 12'h00C, IN_LO = 12'h010;
  localparam logic [11:0] FALL_LO = 12'h014, RISE_LO = 12'h018, STAT_LO = 12'h020;
  localparam logic [11:0] OE_HI = 12'h508, OUT_HI = 12'h50C, IN_HI = 12'h510;
  localparam logic [11:0] FALL_HI = 12'h514, RISE_HI = 12'h518, STAT_HI = 12'h520;

  always #5 clk = ~clk;

  gpio_halfword_edge u_gpio_halfword_edge (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_i(pin_i), .irq(irq),
    .bright_lvl(bright_lvl), .i2c_sda(i2c_sda), .i2c_scl(i2c_scl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [2:0] exp_bright(input logic [2:0] o, input logic [2:0] e);
    if (o == 0 && e == 7) return 0;
    if (o == 2 && e == 0) return 1;
    if (o == 2 && e == 1) return 2;
    if (o == 4 && e == 0) return 3;
    if (o == 1 && e == 6) return 4;
    if (o == 2 && e == 5) return 5;
    if (o == 4 && e == 3) return 6;
    return 7;
  endfunction

  task automatic t_reset();
    logic [15:0] v;
    rd(IN_LO, v);   chk("R3 input low half", v, 16'hFFFF);
    rd(IN_HI, v);   chk("R3 input high half", v, 16'hFFFF);
    rd(OUT_HI, v);  chk("R3 output high half", v, 0);
    rd(RISE_LO, v); chk("R3 rising enable", v, 0);
    rd(STAT_HI, v); chk("R3 status", v, 0);
    rd(OE_HI, v);   chk("R3 oe bits", v, 0);
    chk("R3 irq", irq, 0);
    chk("R3 brightness", bright_lvl, 7);
    chk("R3 i2c", {i2c_sda, i2c_scl}, 0);
  endtask

  task automatic t_halves();
    logic [15:0] v;
    wr(OUT_LO, 16'h1234);
    rd(OUT_LO, v);  chk("R2 output low written", v, 16'h1234);
    rd(OUT_HI, v);  chk("R2 output high untouched", v, 0);
    wr(FALL_HI, 16'hBEEF);
    rd(FALL_HI, v); chk("R1 falling enable high offset", v, 16'hBEEF);
    rd(FALL_LO, v); chk("R2 falling enable low untouched", v, 0);
    wr(FALL_HI, 16'h0000);
    wr(OUT_LO, 16'h0000);
    rd(12'h004, v); chk("R1 unmapped read", v, 0);
    wr(IN_LO, 16'h0000);
    rd(IN_LO, v);   chk("R1 input write ignored", v, 16'hFFFF);
  endtask

  task automatic t_rise();
    logic [15:0] v;
    pin_i[5] = 1'b0;
    tick(3);
    rd(IN_LO, v);   chk("R6 input follows pin", v, 16'hFFDF);
    chk("R6 no irq without enable", irq, 0);
    rd(STAT_LO, v); chk("R6 status unchanged", v, 0);
    wr(RISE_LO, 16'h0020);
    pin_i[5] = 1'b1;
    tick(1);
    chk("R4 not yet after one edge", irq, 0);
    tick(1);
    chk("R4 irq after second edge", irq, 1);
    rd(STAT_LO, v); chk("R4 status mask", v, 16'h0020);
    wr(STAT_HI, 16'h1234);
    chk("R9 irq cleared", irq, 0);
    rd(STAT_LO, v); chk("R9 status cleared", v, 0);
  endtask

  task automatic t_fall();
    logic [15:0] v;
    wr(FALL_HI, 16'h0010);
    pin_i[20] = 1'b0;
    tick(2);
    rd(STAT_HI, v); chk("R5 status high mask", v, 16'h0010);
    rd(STAT_LO, v); chk("R5 status low zero", v, 0);
    chk("R5 irq", irq, 1);
    wr(RISE_LO, 16'h0028);
    pin_i[3] = 1'b0;
    tick(3);
    rd(STAT_HI, v); chk("R6 fall without enable keeps status", v, 16'h0010);
    pin_i[3] = 1'b1;
    tick(2);
    rd(STAT_LO, v); chk("R7 overwritten low", v, 16'h0008);
    rd(STAT_HI, v); chk("R7 overwritten high", v, 0);
    wr(STAT_LO, 16'h0);
    chk("R9 cleared by low half", irq, 0);
  endtask

  task automatic t_simul();
    logic [15:0] v;
    wr(FALL_LO, 16'h1200);
    pin_i[9] = 1'b0; pin_i[12] = 1'b0;
    tick(2);
    rd(STAT_LO, v); chk("R8 lowest pin recorded", v, 16'h0200);
    wr(RISE_LO, 16'h1000);
    pin_i[12] = 1'b1;
    @(posedge clk); @(negedge clk);
    wr(STAT_LO, 16'h0);
    rd(STAT_LO, v); chk("R9 edge wins over clear", v, 16'h1000);
    chk("R9 irq stays high", irq, 1);
    wr(STAT_HI, 16'h0);
    chk("R9 irq low after clear", irq, 0);
  endtask

  task automatic t_oe();
    logic [15:0] v;
    wr(OE_HI, 16'hFFFD);
    rd(OE_HI, v);  chk("R10 oe keeps three bits", v, 16'h0005);
    wr(OE_LO, 16'h0007);
    rd(OE_LO, v);  chk("R10 low oe reads zero", v, 0);
    rd(OE_HI, v);  chk("R10 low oe write ignored", v, 16'h0005);
    chk("R11 unlisted pair gives 7", bright_lvl, 7);
  endtask

  task automatic t_bright();
    logic [2:0] ol [9] = '{0, 2, 2, 4, 1, 2, 4, 3, 0};
    logic [2:0] el [9] = '{7, 0, 1, 0, 6, 5, 3, 4, 0};
    for (int i = 0; i < 9; i++) begin
      wr(OUT_HI, {13'd0, ol[i]});
      wr(OE_HI, {13'd0, el[i]});
      chk("R11 brightness table", bright_lvl, exp_bright(ol[i], el[i]));
    end
    wr(OUT_HI, 16'h0002);
    wr(OE_HI, 16'h0005);
    chk("R11 level 5", bright_lvl, 5);
    wr(OUT_LO, 16'hFFFF);
    chk("R11 low output write no effect", bright_lvl, 5);
    wr(OUT_HI, 16'h2000);
    chk("R12 sda high scl low", {i2c_sda, i2c_scl}, 2'b10);
    chk("R11 level from new output bits", bright_lvl, 7);
    wr(OUT_HI, 16'h4000);
    chk("R12 sda low scl high", {i2c_sda, i2c_scl}, 2'b01);
    wr(OUT_LO, 16'h0000);
    chk("R12 low output write no effect", {i2c_sda, i2c_scl}, 2'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_halves();
    t_rise();
    t_fall();
    t_simul();
    t_oe();
    t_bright();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule